// File: doc/BRIEF.md
# Two-Stage UART Baud Tick Generator

This block derives the two timing enables a UART needs from a single reference clock. An optional divide-by-8 prescale comes first. A 16-bit clock divisor follows it and produces the sample-rate enable. An 8-bit bit divisor then counts sample enables and produces the bit-rate enable. The resulting bit rate is the selected clock divided by `clk_div * (bit_div + 1)`. Both enables are single-cycle pulses in the reference clock domain. No derived clock is created.

Software programs three registers through a small synchronous register port and can read them back. Illegal divisor values are dropped without any indication, and the register keeps its old value. This means that a clock divisor of zero, or a bit divisor below four, can never reach the counters. A divisor written in the middle of a period does not change that period. The new value is loaded the next time the counter reloads.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held and after it is released, the clock divisor reads 0x028B, the bit divisor reads 0x0F and the prescale bit reads 0. Both tick outputs are low in the first cycle after a reset cycle.
- R2: With the prescale bit clear, `sample_tick` is a one-cycle pulse every `clk_div` clock cycles. With `clk_div` = 1 it is high on every cycle.
- R3: With the prescale bit set, `sample_tick` pulses every `8 * clk_div` clock cycles. Two pulses are never on consecutive cycles.
- R4: `bit_tick` pulses once per `bit_div + 1` sample ticks and is only ever high together with `sample_tick`. This gives a bit interval of `clk_div * (bit_div + 1)` cycles, times 8 when prescaled.
- R5: A write of 0 to the clock divisor (address 1) is ignored and the old value is kept. Any value from 1 to 0xFFFF is stored in full.
- R6: A write to the bit divisor (address 2) uses `reg_wdata[7:0]` only. A value below 4 is ignored and the old value is kept. A value from 4 to 0xFF is stored.
- R7: A divisor written in the middle of a period takes effect only at the next reload of its counter. The sample or bit period in progress runs to its full old length.
- R8: The register map is as follows. Address 0 holds the prescale bit in bit 0 and reads 0 in bits 15:1. Address 1 is the clock divisor. Address 2 is the bit divisor in bits 7:0 and reads 0 in bits 15:8. Address 3 reads 0 and ignores writes. Read data is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr | input | 2 | Register address for both writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| sample_tick | output | 1 | Sample-rate enable pulse |
| bit_tick | output | 1 | Bit-rate enable pulse |

## Verification
Some properties are checked on every cycle. These are: the alignment of every bit tick with a sample tick, the minimum spacing of sample ticks while prescaled, the quiet outputs after reset, and the filtering of illegal divisor writes, both rejected and accepted. Exact period lengths need the bench's directed scenarios. These cover several divisor settings, both prescale settings and the `clk_div` = 1 boundary. The same applies to the deferred reload after a mid-period write and to the register read-back map. The bench measures these intervals at the ports.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int CD_W      = 16;
    localparam int BD_W      = 8;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int PRE_RATIO = 8;
    localparam int PRE_W     = $clog2(PRE_RATIO);
    localparam int BD_MIN    = 4;

    localparam logic [CD_W-1:0] CD_RST = CD_W'(16'h028B);
    localparam logic [BD_W-1:0] BD_RST = BD_W'(8'h0F);

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MODE   = 2'd0,
        ADDR_CLKDIV = 2'd1,
        ADDR_BITDIV = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic            prescale;
        logic [CD_W-1:0] clk_div;
        logic [BD_W-1:0] bit_div;
    } baud_cfg_t;

    function automatic logic clk_div_ok(input logic [CD_W-1:0] v);
        return v != '0;
    endfunction

    function automatic logic bit_div_ok(input logic [BD_W-1:0] v);
        return v >= BD_W'(BD_MIN);
    endfunction
endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output baud_cfg_t         cfg,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.prescale <= 1'b0;
            cfg.clk_div  <= CD_RST;
            cfg.bit_div  <= BD_RST;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                ADDR_MODE:   cfg.prescale <= wr_data[0];
                ADDR_CLKDIV: if (clk_div_ok(wr_data[CD_W-1:0])) cfg.clk_div <= wr_data[CD_W-1:0];
                ADDR_BITDIV: if (bit_div_ok(wr_data[BD_W-1:0])) cfg.bit_div <= wr_data[BD_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(addr))
            ADDR_MODE:   rd_data[0]        = cfg.prescale;
            ADDR_CLKDIV: rd_data[CD_W-1:0] = cfg.clk_div;
            ADDR_BITDIV: rd_data[BD_W-1:0] = cfg.bit_div;
            default:     rd_data           = '0;
        endcase
    end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable_div,
    output logic ref_en
);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_RATIO - 1);

    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign ref_en = enable_div ? (cnt == LAST) : 1'b1;
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int             W       = 16,
    parameter logic [W-1:0]   RST_VAL = W'(1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] reload,
    output logic         fire
);
    logic [W-1:0] cnt;

    assign fire = step && (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= RST_VAL;
        end else if (step) begin
            cnt <= (cnt == W'(1)) ? reload : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sample_tick,
    output logic              bit_tick
);
    localparam int BC_W = BD_W + 1;
    localparam logic [BC_W-1:0] BC_RST = BC_W'(BD_RST) + BC_W'(1);

    baud_cfg_t       cfg;
    logic            ref_en;
    logic            s_fire;
    logic            b_fire;
    logic [BC_W-1:0] bit_reload;

    baud_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .cfg     (cfg),
        .rd_data (reg_rdata)
    );

    baud_prescale u_pre (
        .clk        (clk),
        .rst        (rst),
        .enable_div (cfg.prescale),
        .ref_en     (ref_en)
    );

    baud_divider #(.W(CD_W), .RST_VAL(CD_RST)) u_sample_div (
        .clk    (clk),
        .rst    (rst),
        .step   (ref_en),
        .reload (cfg.clk_div),
        .fire   (s_fire)
    );

    assign bit_reload = BC_W'(cfg.bit_div) + BC_W'(1);

    baud_divider #(.W(BC_W), .RST_VAL(BC_RST)) u_bit_div (
        .clk    (clk),
        .rst    (rst),
        .step   (s_fire),
        .reload (bit_reload),
        .fire   (b_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_tick <= 1'b0;
            bit_tick    <= 1'b0;
        end else begin
            sample_tick <= s_fire;
            bit_tick    <= b_fire;
        end
    end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
    import baud_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              sample_tick,
    input logic              bit_tick,
    input logic              prescale,
    input logic [CD_W-1:0]   cd_val,
    input logic [BD_W-1:0]   bd_val
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sample_tick && !bit_tick));

    p_bit_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    p_prescale_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (prescale && $past(prescale) && sample_tick) |=> !sample_tick);

    p_cd_reject_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[CD_W-1:0] == '0) |=> $stable(cd_val));

    p_cd_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[CD_W-1:0] != '0)
            |=> cd_val == $past(reg_wdata[CD_W-1:0]));

    p_bd_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[BD_W-1:0] < BD_W'(BD_MIN)) |=> $stable(bd_val));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .prescale    (cfg.prescale),
    .cd_val      (cfg.clk_div),
    .bd_val      (cfg.bit_div)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        sample_tick;
    logic        bit_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    baud_tick_gen uut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic next_sample(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_tick && n < 200000);
    endtask

    task automatic next_bit(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < 200000);
    endtask

    task automatic sample_interval(output int n);
        int d;
        next_sample(d);
        next_sample(n);
    endtask

    task automatic bit_interval(output int cyc, output int samples, output int misaligned);
        int d;
        next_bit(d);
        cyc = 0; samples = 0; misaligned = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (sample_tick) samples++;
            if (bit_tick && !sample_tick) misaligned++;
        end while (!bit_tick && cyc < 200000);
    endtask

    task automatic t_reset();
        int v, c, s, m;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 tick low in reset", int'(sample_tick | bit_tick), 0);
        rd(2'd1, v); chk("R1 clk_div reset", v, 16'h028B);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ticks low after reset", int'(sample_tick | bit_tick), 0);
        rd(2'd2, v); chk("R1 bit_div reset", v, 8'h0F);
        rd(2'd0, v); chk("R1 prescale reset", v, 0);
        sample_interval(v); chk("R2 reset sample interval", v, 651);
        bit_interval(c, s, m);
        chk("R4 reset bit interval", c, 651 * 16);
        chk("R4 reset samples per bit", s, 16);
        chk("R4 reset alignment", m, 0);
    endtask

    task automatic t_regmap();
        int v;
        wr(2'd0, 16'h0001); rd(2'd0, v); chk("R8 mode bit set", v, 1);
        wr(2'd0, 16'hFFFE); rd(2'd0, v); chk("R8 mode upper bits ignored", v, 0);
        wr(2'd3, 16'hFFFF); rd(2'd3, v); chk("R8 spare address reads 0", v, 0);
        wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R5 clk_div max stored", v, 16'hFFFF);
        wr(2'd2, 16'h12FF); rd(2'd2, v); chk("R6 bit_div low byte only", v, 8'hFF);
        wr(2'd1, 16'd10);   rd(2'd1, v); chk("R5 clk_div 10 stored", v, 10);
        wr(2'd2, 16'd4);    rd(2'd2, v); chk("R6 bit_div 4 stored", v, 4);
    endtask

    task automatic t_cd_reject();
        int v;
        wr(2'd1, 16'd0); rd(2'd1, v); chk("R5 zero clk_div ignored", v, 10);
        sample_interval(v); sample_interval(v);
        chk("R5 period unchanged after zero write", v, 10);
    endtask

    task automatic t_bd_reject();
        int v;
        wr(2'd2, 16'd5);    rd(2'd2, v); chk("R6 bit_div 5 stored", v, 5);
        wr(2'd2, 16'd3);    rd(2'd2, v); chk("R6 bit_div 3 ignored", v, 5);
        wr(2'd2, 16'h0100); rd(2'd2, v); chk("R6 bit_div low byte 0 ignored", v, 5);
        wr(2'd2, 16'h0104); rd(2'd2, v); chk("R6 bit_div low byte 4 stored", v, 4);
    endtask

    task automatic t_mode0();
        int v;
        wr(2'd1, 16'd7);
        sample_interval(v); sample_interval(v);
        chk("R2 sample interval cd=7", v, 7);
        @(negedge clk);
        chk("R2 pulse lasts one cycle", int'(sample_tick), 0);
    endtask

    task automatic t_bits();
        int c, s, m;
        bit_interval(c, s, m);
        bit_interval(c, s, m);
        chk("R4 bit interval cd=7 bd=4", c, 35);
        chk("R4 samples per bit bd=4", s, 5);
        wr(2'd2, 16'd6);
        bit_interval(c, s, m);
        chk("R4 bit interval cd=7 bd=6", c, 49);
        chk("R4 samples per bit bd=6", s, 7);
        chk("R4 bit tick aligned", m, 0);
        wr(2'd2, 16'd4);
    endtask

    task automatic t_mode1();
        int v, c, s, m;
        wr(2'd1, 16'd3);
        wr(2'd0, 16'd1);
        sample_interval(v); sample_interval(v);
        chk("R3 prescaled sample interval cd=3", v, 24);
        bit_interval(c, s, m); bit_interval(c, s, m);
        chk("R3 prescaled bit interval", c, 120);
        chk("R4 prescaled samples per bit", s, 5);
        wr(2'd0, 16'd0);
    endtask

    task automatic t_cd_one();
        int v, c, s, m;
        wr(2'd1, 16'd1);
        sample_interval(v); sample_interval(v);
        chk("R2 cd=1 ticks every cycle", v, 1);
        bit_interval(c, s, m); bit_interval(c, s, m);
        chk("R4 cd=1 bit interval", c, 5);
        chk("R4 cd=1 samples per bit", s, 5);
    endtask

    task automatic t_defer();
        int v, n, c, s, m;
        wr(2'd1, 16'd10);
        sample_interval(v); sample_interval(v);
        chk("R7 settled cd=10", v, 10);
        wr(2'd1, 16'd3);
        n = 1;
        while (!sample_tick && n < 200000) begin
            @(negedge clk);
            n++;
        end
        chk("R7 running sample period keeps old cd", n, 10);
        next_sample(v); chk("R7 new cd after reload", v, 3);
        bit_interval(c, s, m); bit_interval(c, s, m);
        chk("R7 settled bit interval cd=3 bd=4", c, 15);
        wr(2'd2, 16'd9);
        n = 1;
        while (!bit_tick && n < 200000) begin
            @(negedge clk);
            n++;
        end
        chk("R7 running bit period keeps old bd", n, 15);
        next_bit(v); chk("R7 new bd after reload", v, 30);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_regmap();
        t_cd_reject();
        t_bd_reject();
        t_mode0();
        t_bits();
        t_mode1();
        t_cd_one();
        t_defer();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule